// File: doc/BRIEF.md
# Packed SIMD Saturating Adder/Subtractor

This execution slice adds or subtracts two 64-bit packed operands lane by lane. The caller selects the lane width (eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes) and one of three overflow policies: plain wrap-around, clamping to the signed range, or clamping to the unsigned range. Subtraction always computes the destination operand minus the source operand, and the result is what would be written back to the destination. Carries and borrows stop at every lane boundary, so each lane behaves as an independent adder.

A request is presented with `in_valid` together with both operands, a 3-bit operation code and a 2-bit lane-size code. One clock later the result appears with `out_valid`. The saturating policies exist only for 8-bit and 16-bit lanes. A saturating request at 32-bit lane width, or a reserved code, is rejected: `err` is raised alongside `out_valid` and the result equals the unmodified destination operand.

The output side is a small state machine with three named states. `ST_IDLE` means no result is presented. `ST_RESULT` presents a legal result. `ST_FAULT` presents a rejected request. On every clock the next state depends only on the current request: `in_valid` with a legal code goes to `ST_RESULT` ("accept"), `in_valid` with an illegal code goes to `ST_FAULT` ("reject"), and no request goes to `ST_IDLE` ("drain"). These three transitions are taken from any state.

Top module: `simd_sat_addsub`

## Requirements
- R1: With `op_i[1:0]`=0 (wrap) and `op_i[2]`=0 (add), each lane holds the low bits of dst+src and the carry out of a lane is dropped. Lane size is coded on `size_i` as 0 for 8-bit, 1 for 16-bit and 2 for 32-bit lanes. For example, byte 0xFF plus 0x01 gives 0x00 and leaves the byte above unchanged.
- R2: With `op_i[2]`=1 (subtract) and wrap mode, each lane holds the low bits of dst−src. A borrow never reaches the next lane.
- R3: With `op_i[1:0]`=1 (signed clamp) and add, a lane whose two's-complement sum leaves the lane's range becomes the most positive value (for example 0x7FFF) or the most negative value (for example 0x8000). An in-range sum is exact.
- R4: With signed clamp and subtract, an out-of-range difference dst−src is clamped in the same way.
- R5: With `op_i[1:0]`=2 (unsigned clamp) and add, a lane whose unsigned sum exceeds all-ones becomes all-ones.
- R6: With unsigned clamp and subtract, a lane where src is greater than dst becomes zero.
- R7: An illegal request has `err`=1 with `out_valid`, and the result equals the destination operand unchanged. A request is illegal if it asks for either clamp mode at `size_i`=2, or uses `op_i[1:0]`=3, or uses `size_i`=3. A legal request has `err`=0.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low after a cycle without one.
- R9: After reset `out_valid`, `err` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| dst_i | input | 64 | Destination operand (minuend for subtract) |
| src_i | input | 64 | Source operand |
| op_i | input | 3 | [1:0] overflow policy, [2] subtract |
| size_i | input | 2 | Lane-width code |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| err | output | 1 | Request was illegal; result is the destination operand |
| result_o | output | 64 | Packed result |

## Verification
Directed vectors place operands exactly at the lane extremes: all-ones plus one, the most positive value plus one, the most negative value minus one, and zero minus one. These vectors separate wrap from clamp and signed from unsigned clamping, and a carry that leaks across a lane boundary shows up as a change in the neighbouring lane. Randomized operands then run every mode and lane-size code, including the reserved ones, and the result is compared on every clock with a behavioural lane-by-lane model. Gaps with `in_valid` low between requests check that `out_valid` follows each request by exactly one cycle.

// File: rtl/psau_pkg.sv
package psau_pkg;

    typedef enum logic [1:0] {
        M_WRAP = 2'd0,
        M_SSAT = 2'd1,
        M_USAT = 2'd2,
        M_RSVD = 2'd3
    } arith_mode_e;

    typedef enum logic [1:0] {
        LS_8    = 2'd0,
        LS_16   = 2'd1,
        LS_32   = 2'd2,
        LS_RSVD = 2'd3
    } lane_size_e;

    typedef struct packed {
        arith_mode_e mode;
        logic        sub;
        lane_size_e  size;
        logic        legal;
    } op_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } out_state_e;

endpackage

// File: rtl/psau_op_decode.sv
module psau_op_decode
    import psau_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic [1:0] size_i,
    output op_ctl_t    ctl_o
);
    arith_mode_e mode;
    lane_size_e  size;

    always_comb begin
        mode = arith_mode_e'(op_i[1:0]);
        size = lane_size_e'(size_i);
        ctl_o.mode  = mode;
        ctl_o.sub   = op_i[2];
        ctl_o.size  = size;
        ctl_o.legal = (mode != M_RSVD) && (size != LS_RSVD) &&
                      !((size == LS_32) && (mode != M_WRAP));
    end
endmodule

// File: rtl/psau_lane.sv
module psau_lane
    import psau_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  arith_mode_e  mode_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] raw;
    logic       carry;
    logic       ovf_s;

    always_comb begin
        raw   = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
        carry = raw[W];
        if (sub_i)
            ovf_s = (a_i[W-1] != b_i[W-1]) && (raw[W-1] != a_i[W-1]);
        else
            ovf_s = (a_i[W-1] == b_i[W-1]) && (raw[W-1] != a_i[W-1]);

        unique case (mode_i)
            M_SSAT:  y_o = ovf_s ? (a_i[W-1] ? SMIN : SMAX) : raw[W-1:0];
            M_USAT:  y_o = carry ? (sub_i ? '0 : '1) : raw[W-1:0];
            default: y_o = raw[W-1:0];
        endcase
    end
endmodule

// File: rtl/psau_lane_bank.sv
module psau_lane_bank
    import psau_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int W      = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  arith_mode_e       mode_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] y_o
);
    localparam int NLANES = DATA_W / W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        psau_lane #(.W(W)) u_lane (
            .a_i   (a_i[g*W +: W]),
            .b_i   (b_i[g*W +: W]),
            .mode_i(mode_i),
            .sub_i (sub_i),
            .y_o   (y_o[g*W +: W])
        );
    end
endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub
    import psau_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LW_B   = 8,
    parameter int LW_H   = 16,
    parameter int LW_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    output logic              out_valid,
    output logic              err,
    output logic [DATA_W-1:0] result_o
);
    op_ctl_t           ctl;
    logic [DATA_W-1:0] y_b, y_h, y_w, y_sel;
    out_state_e        state_q, state_d;
    logic [DATA_W-1:0] result_q;

    psau_op_decode u_dec (
        .op_i  (op_i),
        .size_i(size_i),
        .ctl_o (ctl)
    );

    psau_lane_bank #(.DATA_W(DATA_W), .W(LW_B)) u_bank_b (
        .a_i(dst_i), .b_i(src_i), .mode_i(ctl.mode), .sub_i(ctl.sub), .y_o(y_b));
    psau_lane_bank #(.DATA_W(DATA_W), .W(LW_H)) u_bank_h (
        .a_i(dst_i), .b_i(src_i), .mode_i(ctl.mode), .sub_i(ctl.sub), .y_o(y_h));
    psau_lane_bank #(.DATA_W(DATA_W), .W(LW_W)) u_bank_w (
        .a_i(dst_i), .b_i(src_i), .mode_i(ctl.mode), .sub_i(ctl.sub), .y_o(y_w));

    always_comb begin
        unique case (ctl.size)
            LS_8:    y_sel = y_b;
            LS_16:   y_sel = y_h;
            LS_32:   y_sel = y_w;
            default: y_sel = dst_i;
        endcase
        if (!ctl.legal)
            y_sel = dst_i;
    end

    // Next-state logic: accept, reject or drain from any state.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (in_valid)
                    state_d = ctl.legal ? ST_RESULT : ST_FAULT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (in_valid) result_q <= y_sel;
    end

    // Output decode from state.
    always_comb begin
        out_valid = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_RESULT: out_valid = 1'b1;
            ST_FAULT:  begin out_valid = 1'b1; err = 1'b1; end
            default:   ;
        endcase
        result_o = result_q;
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_err_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> out_valid);

    assert_fault_keeps_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_i == 2'd2 && op_i[1:0] != 2'd0)
        |=> (err && result_o == $past(dst_i)));

    assert_usat_add_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 3'b010 && size_i == 2'd0)
        |=> (result_o[7:0] >= $past(dst_i[7:0])));

    assert_usat_sub_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 3'b110 && size_i == 2'd1)
        |=> (result_o[15:0] <= $past(dst_i[15:0])));

endmodule

// File: tb/tb_simd_sat_addsub.sv
`timescale 1ns/1ps
module tb_simd_sat_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] dst_i = '0, src_i = '0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic        out_valid, err;
    logic [63:0] result_o;

    int checks = 0;
    int fails  = 0;

    simd_sat_addsub dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_i(dst_i), .src_i(src_i),
        .op_i(op_i), .size_i(size_i), .out_valid(out_valid), .err(err), .result_o(result_o));

    always #2.5 clk = ~clk;

    // Expected state for the cycle after the current request.
    logic        exp_valid = 1'b0;
    logic        exp_err   = 1'b0;
    logic [63:0] exp_res   = '0;
    string       exp_tag   = "R9";

    function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] s,
                                          input int mode, input bit sub, input int sz,
                                          output bit bad);
        int     w;
        longint mask, half, ua, ub, sa, sb, r;
        logic [63:0] out;
        bad = (mode == 3) || (sz == 3) || (sz == 2 && mode != 0);
        if (bad) return d;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        out = '0;
        for (int k = 0; k < 64 / w; k++) begin
            ua = longint'((d >> (k * w))) & mask;
            ub = longint'((s >> (k * w))) & mask;
            if (mode == 1) begin
                sa = (ua >= half) ? ua - 2 * half : ua;
                sb = (ub >= half) ? ub - 2 * half : ub;
                r = sub ? sa - sb : sa + sb;
                if (r > half - 1) r = half - 1;
                if (r < -half)    r = -half;
            end else begin
                r = sub ? ua - ub : ua + ub;
                if (mode == 2) begin
                    if (r > mask) r = mask;
                    if (r < 0)    r = 0;
                end
            end
            out = out | (64'(r & mask) << (k * w));
        end
        return out;
    endfunction

    function automatic string tag_of(input int mode, input bit sub, input bit bad);
        if (bad)       return "R7";
        if (mode == 0) return sub ? "R2" : "R1";
        if (mode == 1) return sub ? "R4" : "R3";
        return sub ? "R6" : "R5";
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_valid) begin
            fails++;
            $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
        end
        if (exp_valid || exp_tag == "R9") begin
            checks++;
            if (err !== exp_err || result_o !== exp_res) begin
                fails++;
                $display("FAIL %s result actual=%h err=%0b expected=%h err=%0b",
                         exp_tag, result_o, err, exp_res, exp_err);
            end
        end
    endtask

    // Drive one cycle; check outputs of the previous cycle first.
    task automatic cycle(input bit v, input logic [63:0] d, input logic [63:0] s,
                         input int mode, input bit sub, input int sz);
        bit bad;
        logic [63:0] r;
        @(negedge clk);
        compare();
        in_valid = v; dst_i = d; src_i = s;
        op_i = {sub, 2'(mode)}; size_i = 2'(sz);
        r = model(d, s, mode, sub, sz, bad);
        exp_valid = v;
        if (v) begin
            exp_res = r;
            exp_err = bad;
            exp_tag = tag_of(mode, sub, bad);
        end else begin
            exp_tag = "R8";
        end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state checked by first compare (exp_tag R9, all zero)
        // R1: byte wrap, carry must not reach next byte
        cycle(1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 0, 0, 0);
        // R1: 16 and 32 bit wrap
        cycle(1, 64'h1234_FFFF_0001_FFFF, 64'h0001_0001_FFFF_0002, 0, 0, 1);
        cycle(1, 64'hFFFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, 0, 0, 2);
        cycle(0, '0, '0, 0, 0, 0);
        // R2: borrow confined to lane
        cycle(1, 64'h0100_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 1, 0);
        cycle(1, 64'h0000_0005_0000_0003, 64'h0000_0001_0000_0004, 0, 1, 2);
        // R3: signed clamp add
        cycle(1, 64'h7FFF_8000_0010_7FFF, 64'h0001_FFFF_0020_7FFF, 1, 0, 1);
        cycle(1, 64'h7F80_7F80_0102_7F80, 64'h0180_017F_FF01_7F80, 1, 0, 0);
        // R4: signed clamp subtract
        cycle(1, 64'h8000_7FFF_0005_8000, 64'h0001_FFFF_0003_7FFF, 1, 1, 1);
        cycle(1, 64'h807F_0080_7F80_1020, 64'h01FF_7F01_807F_2010, 1, 1, 0);
        // R5: unsigned clamp add
        cycle(1, 64'hFFFF_8000_0001_FFF0, 64'h0001_8000_0002_0020, 2, 0, 1);
        cycle(1, 64'hFF80_0102_FFFE_0000, 64'h0180_0304_0102_0000, 2, 0, 0);
        // R6: unsigned clamp subtract
        cycle(1, 64'h0000_0005_8000_0010, 64'h0001_0003_8001_0010, 2, 1, 1);
        cycle(1, 64'h0001_0203_0405_0607, 64'h0100_0302_0504_0706, 2, 1, 0);
        cycle(0, '0, '0, 0, 0, 0);
        // R7: illegal requests keep destination
        cycle(1, 64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444, 1, 0, 2);
        cycle(1, 64'hCAFE_F00D_8888_9999, 64'h7777_6666_5555_4444, 2, 1, 2);
        cycle(1, 64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101, 3, 0, 0);
        cycle(1, 64'hA5A5_5A5A_A5A5_5A5A, 64'h0F0F_F0F0_0F0F_F0F0, 0, 0, 3);
        cycle(0, '0, '0, 0, 0, 0);
        cycle(0, '0, '0, 0, 0, 0);
        // Random traffic, all codes, with gaps (R8)
        for (int i = 0; i < 2000; i++) begin
            cycle(($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom},
                  int'($urandom % 4), bit'($urandom % 2), int'($urandom % 4));
        end
        cycle(0, '0, '0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule